// File: doc/BRIEF.md
# Latency-Based Issue Interlock

This block decides, cycle by cycle, whether the next instruction of an in-order, single-issue pipeline may leave decode. The pipeline has pipelined floating-point units and full forwarding, so a consumer only waits when a producer's result is not yet available to it. How long it must wait depends on the classes of both producer and consumer. The block holds a short record of the producers issued in the last few cycles. It compares the sources of the waiting instruction with that record and looks up the required separation in a producer-by-consumer latency table.

When any source is still too close to its producer, the block lowers `ready`. The instruction stays at the input and one stall is counted. Branches resolve in decode and have one delay slot. The block flags the instruction that occupies the slot. A bubble placed in the slot on purpose is a wasted cycle and is counted as a stall. A free-running cycle counter advances on every active cycle. Together the two counters give the cost of a code sequence.

The register fields are six bits wide. Bit 5 selects the floating-point file (1) or the integer file (0), and the low five bits give the index.

Top module: `iss_interlock`

## Requirements
- R1: While `rst_n` is low, `cycle_cnt`, `stall_cnt` and `in_slot` are zero and the producer record is emptied. A consumer presented right after reset therefore issues without waiting.
- R2: A result of an FP op (class 0) read by a later FP op needs 3 cycles of separation. It gives 3 stalls when the two are adjacent, 2 with one instruction or idle cycle between, and 0 from three on. Register fields use bit 5 = 1 for FP registers.
- R3: A result of an FP op read as store data (class 2, data register in `in_src2`, base in `in_src1`) gives 2 stalls when the two are adjacent.
- R4: A load result (class 1, base in `in_src1`) read by an FP op gives 1 stall when adjacent. The same result read as store data gives none.
- R5: A branch (class 4, compared registers in `in_src1`/`in_src2`) that reads an integer register written by the directly preceding integer op (class 3) waits 1 cycle. With one instruction between, it waits none.
- R6: With several sources hazarded, the wait is the largest of their individual waits. While waiting, `ready` is low, the instruction stays at the input, and `stall_cnt` rises by one per held cycle. An instruction that issues at once adds nothing to it.
- R7: `cycle_cnt` rises by one on every cycle with `active` high, including cycles with no valid instruction, and those idle cycles age producers. With `active` low, `ready` is low and the counters and producer record hold.
- R8: `in_slot` is high from the cycle after a branch issues until the next instruction issues. A bubble (class 5) never waits, and its issue adds one to `stall_cnt`.
- R9: These pairs never wait: integer op to integer op, integer op to load or store base, and load to store data. Registers whose low five bits match but whose file bit differs never interact.
- R10: On code sequences, the total cycles are fixed as follows:
  - load/add/store/decrement/branch/bubble takes 10 cycles;
  - load/decrement/add/branch/store-in-slot takes 6 cycles;
  - the four-way unrolled, renamed and scheduled 14-instruction body takes 14 cycles with no stall;
  - the same body unscheduled, ending in a bubble slot, takes 28 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active | input | 1 | Pipeline running; low freezes the block |
| in_valid | input | 1 | An instruction is presented |
| in_class | input | 3 | 0 FP op, 1 load, 2 store, 3 integer op, 4 branch, 5 bubble |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source (base for loads and stores) |
| in_src2 | input | REG_W | Second source (data for stores) |
| ready | output | 1 | The presented instruction issues at this clock edge |
| in_slot | output | 1 | The presented instruction sits in a branch delay slot |
| cycle_cnt | output | CNT_W | Active cycles |
| stall_cnt | output | CNT_W | Held cycles plus issued bubbles |

## Verification
The block is driven with whole loop bodies in four forms: plain, reordered with a filled slot, unrolled and unscheduled, and unrolled and scheduled. Their fixed cycle totals show whether the latency table, the branch rule and the slot bubble combine correctly. Short chains of FP ops at distances one and two separate a true age count from a plain adjacency test. A pair of sources with different producers shows whether the largest wait is taken rather than the first one found. Zero-latency pairs and registers that differ only in the file bit must pass freely. Separate tests cover idle aging, freezing with `active` low, and a reset between producer and consumer, which tell apart a record that ages with time, one that ages with issue, and one that survives reset.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [2:0] {
    CL_FPOP   = 3'd0,
    CL_FLOAD  = 3'd1,
    CL_FSTORE = 3'd2,
    CL_IOP    = 3'd3,
    CL_BR     = 3'd4,
    CL_NOP    = 3'd5
  } icls_e;

  // Longest producer-to-consumer separation in the table; sets record depth.
  localparam int MAX_LAT = 3;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  // Cycles of separation a consumer needs after a producer.
  function automatic logic [LAT_W-1:0] lat_of(icls_e prod, icls_e cons);
    logic [LAT_W-1:0] l;
    l = '0;
    case (prod)
      CL_FPOP: begin
        if (cons == CL_FPOP)        l = LAT_W'(3);
        else if (cons == CL_FSTORE) l = LAT_W'(2);
      end
      CL_FLOAD: begin
        if (cons == CL_FPOP) l = LAT_W'(1);
      end
      CL_IOP: begin
        if (cons == CL_BR) l = LAT_W'(1);
      end
      default: l = '0;
    endcase
    return l;
  endfunction

  function automatic logic writes_dst(icls_e c);
    return (c == CL_FPOP) || (c == CL_FLOAD) || (c == CL_IOP);
  endfunction

  function automatic logic reads_src(icls_e c);
    return (c == CL_FPOP) || (c == CL_FLOAD) || (c == CL_FSTORE) ||
           (c == CL_IOP)  || (c == CL_BR);
  endfunction

endpackage

// File: rtl/iss_hist.sv
module iss_hist
  import iss_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             push_vld,
  input  icls_e            push_cls,
  input  logic [REG_W-1:0] push_dst,
  output logic [DEPTH-1:0] h_vld,
  output icls_e            h_cls [DEPTH],
  output logic [REG_W-1:0] h_dst [DEPTH]
);

  logic [DEPTH-1:0] vld_n;
  icls_e            cls_n [DEPTH];
  logic [REG_W-1:0] dst_n [DEPTH];

  // Slot 0 is the producer of the previous active cycle; slot k is k+1 cycles old.
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k == 0) begin : g_head
      assign vld_n[k] = push_vld;
      assign cls_n[k] = push_cls;
      assign dst_n[k] = push_dst;
    end else begin : g_tail
      assign vld_n[k] = h_vld[k-1];
      assign cls_n[k] = h_cls[k-1];
      assign dst_n[k] = h_dst[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        h_cls[k] <= CL_NOP;
        h_dst[k] <= '0;
      end
    end else if (adv) begin
      h_vld <= vld_n;
      for (int k = 0; k < DEPTH; k++) begin
        h_cls[k] <= cls_n[k];
        h_dst[k] <= dst_n[k];
      end
    end
  end

endmodule

// File: rtl/iss_hazard.sv
module iss_hazard
  import iss_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int DEPTH = 3
) (
  input  icls_e            cur_cls,
  input  logic [REG_W-1:0] src1,
  input  logic [REG_W-1:0] src2,
  input  logic [DEPTH-1:0] h_vld,
  input  icls_e            h_cls [DEPTH],
  input  logic [REG_W-1:0] h_dst [DEPTH],
  output logic             hazard
);

  logic             uses;
  logic [DEPTH-1:0] hit;

  assign uses = reads_src(cur_cls);

  // Entry k is k+1 cycles old: k cycles lie between it and the consumer.
  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic match;
    logic close;
    assign match  = uses && ((h_dst[k] == src1) || (h_dst[k] == src2));
    assign close  = int'(lat_of(h_cls[k], cur_cls)) > k;
    assign hit[k] = h_vld[k] && match && close;
  end

  assign hazard = |hit;

endmodule

// File: rtl/iss_cnt.sv
module iss_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stall_inc,
  output logic [CNT_W-1:0] cyc,
  output logic [CNT_W-1:0] stl
);

  logic [CNT_W-1:0] cyc_n;
  logic [CNT_W-1:0] stl_n;

  always_comb begin
    cyc_n = cyc + CNT_W'(1);
    stl_n = stl + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      stl <= '0;
    end else begin
      if (tick)      cyc <= cyc_n;
      if (stall_inc) stl <= stl_n;
    end
  end

endmodule

// File: rtl/iss_interlock.sv
module iss_interlock
  import iss_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             in_valid,
  input  logic [2:0]       in_class,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             ready,
  output logic             in_slot,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] stall_cnt
);

  localparam int DEPTH = MAX_LAT;

  icls_e            cur_cls;
  logic             hazard;
  logic             issue;
  logic             push_vld;
  logic             stall_inc;
  logic             slot_q;
  logic             slot_n;
  logic [DEPTH-1:0] h_vld;
  icls_e            h_cls [DEPTH];
  logic [REG_W-1:0] h_dst [DEPTH];

  assign cur_cls = icls_e'(in_class);

  iss_hist #(.REG_W(REG_W), .DEPTH(DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (active),
    .push_vld (push_vld),
    .push_cls (cur_cls),
    .push_dst (in_dst),
    .h_vld    (h_vld),
    .h_cls    (h_cls),
    .h_dst    (h_dst)
  );

  iss_hazard #(.REG_W(REG_W), .DEPTH(DEPTH)) u_haz (
    .cur_cls (cur_cls),
    .src1    (in_src1),
    .src2    (in_src2),
    .h_vld   (h_vld),
    .h_cls   (h_cls),
    .h_dst   (h_dst),
    .hazard  (hazard)
  );

  iss_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (active),
    .stall_inc (stall_inc),
    .cyc       (cycle_cnt),
    .stl       (stall_cnt)
  );

  always_comb begin
    issue     = active && in_valid && !hazard;
    ready     = active && !(in_valid && hazard);
    push_vld  = issue && writes_dst(cur_cls);
    stall_inc = active && in_valid && (hazard || (cur_cls == CL_NOP));
    slot_n    = (cur_cls == CL_BR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slot_q <= 1'b0;
    else if (issue) slot_q <= slot_n;
  end

  assign in_slot = slot_q;

endmodule

// File: rtl/iss_interlock_chk.sv
module iss_interlock_chk
  import iss_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             in_valid,
  input logic [2:0]       in_class,
  input logic [REG_W-1:0] in_dst,
  input logic [REG_W-1:0] in_src1,
  input logic [REG_W-1:0] in_src2,
  input logic             ready,
  input logic             in_slot,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] stall_cnt
);

  logic             fp_prev_q;
  logic [REG_W-1:0] fp_dst_q;
  logic             go;
  icls_e            cls;

  assign cls = icls_e'(in_class);
  assign go  = active && in_valid && ready;

  // Records whether the previous active cycle issued an FP op, and its target.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_prev_q <= 1'b0;
      fp_dst_q  <= '0;
    end else if (active) begin
      fp_prev_q <= go && (cls == CL_FPOP);
      fp_dst_q  <= in_dst;
    end
  end

  a_r1_reset_counts: assert property (@(posedge clk)
    !rst_n |-> (cycle_cnt == '0) && (stall_cnt == '0) && !in_slot);

  a_r2_fp_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    fp_prev_q && active && in_valid && (cls == CL_FPOP) &&
    ((in_src1 == fp_dst_q) || (in_src2 == fp_dst_q)) |-> !ready);

  a_r3_store_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    fp_prev_q && active && in_valid && (cls == CL_FSTORE) &&
    (in_src2 == fp_dst_q) |-> !ready);

  a_r6_held_counts: assert property (@(posedge clk) disable iff (!rst_n)
    active && in_valid && !ready |=> (stall_cnt - $past(stall_cnt)) == CNT_W'(1));

  a_r6_issue_free: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cls != CL_NOP) |=> $stable(stall_cnt));

  a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cycle_cnt - $past(cycle_cnt)) == CNT_W'(1));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(cycle_cnt) && $stable(stall_cnt) && $stable(in_slot));

  a_r7_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> active);

  a_r8_slot_set: assert property (@(posedge clk) disable iff (!rst_n)
    go && (cls == CL_BR) |=> in_slot);

  a_r8_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot && go && (cls != CL_BR) |=> !in_slot);

  a_r8_bubble_free: assert property (@(posedge clk) disable iff (!rst_n)
    active && in_valid && (cls == CL_NOP) |-> ready);

endmodule

bind iss_interlock iss_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_iss_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .in_valid  (in_valid),
  .in_class  (in_class),
  .in_dst    (in_dst),
  .in_src1   (in_src1),
  .in_src2   (in_src2),
  .ready     (ready),
  .in_slot   (in_slot),
  .cycle_cnt (cycle_cnt),
  .stall_cnt (stall_cnt)
);

// File: tb/test_iss_interlock.sv
module test_iss_interlock;

  localparam int CLK_PERIOD = 10;
  localparam int NV   = 55;
  localparam int NSEG = 8;

  // Vector: {class[2:0], dst[5:0], src1[5:0], src2[5:0], expected_wait[1:0], segment_end}
  localparam logic [23:0] VEC [NV] = '{
    // segment 0: plain loop body, bubble in slot
    {3'd1, 6'h20, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h24, 6'h20, 6'h22, 2'd1, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h24, 2'd2, 1'b0},
    {3'd3, 6'h01, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd4, 6'h00, 6'h01, 6'h02, 2'd1, 1'b0},
    {3'd5, 6'h00, 6'h00, 6'h00, 2'd0, 1'b1},
    // segment 1: reordered, store in slot
    {3'd1, 6'h20, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd3, 6'h01, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h24, 6'h20, 6'h22, 2'd0, 1'b0},
    {3'd4, 6'h00, 6'h01, 6'h02, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h24, 2'd1, 1'b1},
    // segment 2: unrolled, renamed, scheduled
    {3'd1, 6'h20, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd1, 6'h26, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd1, 6'h2A, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd1, 6'h2E, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h24, 6'h20, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h28, 6'h26, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h2C, 6'h2A, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h30, 6'h2E, 6'h22, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h24, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h28, 2'd0, 1'b0},
    {3'd3, 6'h01, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h2C, 2'd0, 1'b0},
    {3'd4, 6'h00, 6'h01, 6'h02, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h30, 2'd0, 1'b1},
    // segment 3: unrolled, renamed, unscheduled
    {3'd1, 6'h20, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h24, 6'h20, 6'h22, 2'd1, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h24, 2'd2, 1'b0},
    {3'd1, 6'h26, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h28, 6'h26, 6'h22, 2'd1, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h28, 2'd2, 1'b0},
    {3'd1, 6'h2A, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h2C, 6'h2A, 6'h22, 2'd1, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h2C, 2'd2, 1'b0},
    {3'd1, 6'h2E, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h30, 6'h2E, 6'h22, 2'd1, 1'b0},
    {3'd2, 6'h00, 6'h01, 6'h30, 2'd2, 1'b0},
    {3'd3, 6'h01, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd4, 6'h00, 6'h01, 6'h02, 2'd1, 1'b0},
    {3'd5, 6'h00, 6'h00, 6'h00, 2'd0, 1'b1},
    // segment 4: FP chain
    {3'd0, 6'h22, 6'h24, 6'h26, 2'd0, 1'b0},
    {3'd0, 6'h2A, 6'h22, 6'h28, 2'd3, 1'b0},
    {3'd0, 6'h2C, 6'h2A, 6'h22, 2'd3, 1'b1},
    // segment 5: two hazarded sources, largest wins
    {3'd0, 6'h34, 6'h36, 6'h38, 2'd0, 1'b0},
    {3'd1, 6'h3A, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd0, 6'h3C, 6'h3A, 6'h34, 2'd2, 1'b1},
    // segment 6: zero-latency pairs and file bit
    {3'd3, 6'h04, 6'h01, 6'h00, 2'd0, 1'b0},
    {3'd3, 6'h05, 6'h04, 6'h00, 2'd0, 1'b0},
    {3'd1, 6'h2B, 6'h05, 6'h00, 2'd0, 1'b0},
    {3'd2, 6'h00, 6'h05, 6'h2B, 2'd0, 1'b0},
    {3'd0, 6'h26, 6'h22, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h2A, 6'h06, 6'h06, 2'd0, 1'b1},
    // segment 7: FP op at distance two
    {3'd0, 6'h2D, 6'h22, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h2E, 6'h22, 6'h22, 2'd0, 1'b0},
    {3'd0, 6'h2F, 6'h2D, 6'h22, 2'd2, 1'b1}
  };

  localparam int SEG_CYC [NSEG] = '{10, 6, 14, 28, 9, 5, 6, 5};
  localparam int SEG_STL [NSEG] = '{5, 1, 0, 14, 6, 2, 0, 2};

  logic        clk;
  logic        rst_n;
  logic        active;
  logic        in_valid;
  logic [2:0]  in_class;
  logic [5:0]  in_dst;
  logic [5:0]  in_src1;
  logic [5:0]  in_src2;
  logic        ready;
  logic        in_slot;
  logic [15:0] cycle_cnt;
  logic [15:0] stall_cnt;

  int checks;
  int failures;
  bit done;

  iss_interlock #(.REG_W(6), .CNT_W(16)) i_iss_interlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_dst    (in_dst),
    .in_src1   (in_src1),
    .in_src2   (in_src2),
    .ready     (ready),
    .in_slot   (in_slot),
    .cycle_cnt (cycle_cnt),
    .stall_cnt (stall_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string seg_tag(int s);
    case (s)
      0: return "R10 R3 R4 R5 R8 loop";
      1: return "R10 R3 R4 reordered";
      2: return "R10 scheduled";
      3: return "R10 R6 unscheduled";
      4: return "R2 R6 chain";
      5: return "R6 max";
      6: return "R9 free pairs";
      default: return "R2 distance";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] c, logic [5:0] d, logic [5:0] s1, logic [5:0] s2);
    in_valid = 1'b1;
    in_class = c;
    in_dst   = d;
    in_src1  = s1;
    in_src2  = s2;
  endtask

  // Called just after a negedge drive: counts held cycles until ready.
  task automatic wait_ready(output int n);
    #1;
    n = 0;
    while (!ready && n < 8) begin
      @(negedge clk);
      #1;
      n++;
    end
  endtask

  task automatic issue_one(logic [2:0] c, logic [5:0] d, logic [5:0] s1, logic [5:0] s2,
                           output int n);
    @(negedge clk);
    drive(c, d, s1, s2);
    wait_ready(n);
  endtask

  task automatic go_idle(int cycles);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int seg;
    bit prev_br;
    logic [15:0] c0, s0, c1, s1v;
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    active = 1'b0;
    in_valid = 1'b0;
    in_class = 3'd5;
    in_dst = '0;
    in_src1 = '0;
    in_src2 = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 cycle_cnt in reset", int'(cycle_cnt), 0);
    chk("R1 stall_cnt in reset", int'(stall_cnt), 0);
    chk("R1 in_slot in reset", int'(in_slot), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready low while inactive", int'(ready), 0);
    chk("R7 cycle_cnt frozen while inactive", int'(cycle_cnt), 0);
    active = 1'b1;
    #1;
    chk("R6 ready high when idle and active", int'(ready), 1);
    go_idle(3);

    // Walk of the vector table
    seg = 0;
    prev_br = 1'b0;
    c0 = '0;
    s0 = '0;
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      @(negedge clk);
      if (i == 0 || VEC[i-1][0]) begin
        c0 = cycle_cnt;
        s0 = stall_cnt;
      end
      drive(v[23:21], v[20:15], v[14:9], v[8:3]);
      #1;
      chk({"R8 slot flag ", seg_tag(seg)}, int'(in_slot), int'(prev_br));
      wait_ready(n);
      chk({"wait count ", seg_tag(seg)}, n, int'(v[2:1]));
      prev_br = (v[23:21] == 3'd4);
      if (v[0]) begin
        @(negedge clk);
        in_valid = 1'b0;
        c1 = cycle_cnt;
        s1v = stall_cnt;
        chk({"total cycles ", seg_tag(seg)}, int'(c1 - c0), SEG_CYC[seg]);
        chk({"stall delta ", seg_tag(seg)}, int'(s1v - s0), SEG_STL[seg]);
        seg++;
        prev_br = 1'b0;
        repeat (3) @(negedge clk);
      end
    end

    // R7: idle active cycle ages the producer
    issue_one(3'd0, 6'h31, 6'h22, 6'h22, n);
    @(negedge clk);
    in_valid = 1'b0;
    issue_one(3'd0, 6'h32, 6'h31, 6'h22, n);
    chk("R7 one idle cycle leaves 2 waits", n, 2);
    go_idle(4);

    // R7: inactive cycles freeze counters and producer record
    issue_one(3'd0, 6'h33, 6'h22, 6'h22, n);
    @(negedge clk);
    in_valid = 1'b0;
    active = 1'b0;
    c0 = cycle_cnt;
    s0 = stall_cnt;
    repeat (5) @(negedge clk);
    #1;
    chk("R7 cycle_cnt frozen", int'(cycle_cnt - c0), 0);
    chk("R7 stall_cnt frozen", int'(stall_cnt - s0), 0);
    chk("R7 ready low when inactive", int'(ready), 0);
    @(negedge clk);
    active = 1'b1;
    drive(3'd0, 6'h35, 6'h33, 6'h22);
    wait_ready(n);
    chk("R7 record not aged while inactive", n, 3);
    go_idle(4);

    // R1: reset between producer and consumer clears record and slot flag
    issue_one(3'd0, 6'h37, 6'h22, 6'h22, n);
    issue_one(3'd4, 6'h00, 6'h01, 6'h02, n);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R8 slot flag after branch", int'(in_slot), 1);
    rst_n = 1'b0;
    #1;
    chk("R1 slot cleared by reset", int'(in_slot), 0);
    chk("R1 cycle_cnt cleared by reset", int'(cycle_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 6'h39, 6'h37, 6'h22);
    wait_ready(n);
    chk("R1 no wait after reset", n, 0);
    go_idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule